// File: doc/BRIEF.md
# Recursive Resonator Tone and Ring Waveform Generator

This block produces signed audio and ringing samples from a two-pole recursive resonator. The recurrence is y[n] = 2·c·y[n-1] − y[n-2]. The coefficient c sets the frequency, and a programmable starting value sets the amplitude. A shared sample-rate counter paces the resonator, with a different clock divisor for each mode. There are three modes:

- Tone mode produces samples at an 8 kHz-class rate.
- Frequency-shift mode produces samples at three times the tone rate. It swaps between a mark setting and a space setting when the serial data bit changes.
- Ring mode produces samples at a 1 kHz-class rate. It can replace the sinusoid with a trapezoid and can add a DC offset.

Each new sample appears on `sample_o` together with a one-cycle `valid_o` pulse.

A four-state machine selects the operating mode:

- **IDLE**: nothing enabled.
- **TONE**: tone enable only.
- **FSK**: tone enable together with shift-keying enable.
- **RING**: ring enable.

Transitions:

- **IDLE→TONE**, **IDLE→FSK** and **IDLE→RING** start a burst.
- Any **active→IDLE** transition ends a burst.
- **TONE↔FSK**, **TONE/FSK→RING** and **RING→TONE/FSK** are direct mode changes. Each one restarts the waveform from its initial state.

Ring and tone share the same oscillator. If both enables are high, the ring mode wins, and a conflict flag is raised one cycle later.

Top module: `reso_wavegen`

## Requirements
- R1: Resonator step and start state.
  - Each sample is sat16(floor(c·y1 / 8192) − y2). Here c is the signed coefficient with 14 fraction bits, y1 is the previous sample and y2 is the sample before it.
  - sat16 clamps the result to the range −32768 to 32767.
  - A restarted waveform uses y1 = 0 and y2 = amplitude, so its first sample is sat16(−amplitude).
- R2: Sample timing.
  - In TONE, FSK and RING, one sample is produced every TONE_DIV, FSK_DIV and RING_DIV clock cycles respectively. All three divisors are at least 2.
  - The first `valid_o` pulse comes exactly DIV cycles after the clock edge that registers the new mode.
- R3: Mode priority.
  - `ring_en` selects RING regardless of the other enables.
  - Otherwise, `tone_en` together with `fsk_en` selects FSK.
  - Otherwise, `tone_en` alone selects TONE.
  - Otherwise the mode is IDLE.
- R4: `conflict_o` equals `tone_en & ring_en` as sampled at the previous clock edge.
- R5: Restart on mode change.
  - Leaving a mode, or changing mode directly, restarts the waveform from its R1 start state at the next sample.
  - No sample is issued on the clock edge where the mode changes.
- R6: FSK mark and space.
  - In FSK, `fsk_bit` = 1 uses the mark coefficient and amplitude, and `fsk_bit` = 0 uses the space settings.
  - At a sample tick where `fsk_bit` differs from the bit used at the previous tick, the resonator restarts with the new settings.
  - While the bit is unchanged, the sequence continues.
- R7: Trapezoid in RING with `trap_sel` = 1.
  - The value v starts at 0 with rising polarity.
  - On each sample, a rising v moves up by `trap_step` but not above the ring amplitude A. A falling v moves down by `trap_step` but not below −A.
  - The polarity flips after every `trap_half` samples.
- R8: DC offset.
  - In RING with `dc_en` = 1, the output is sat16(waveform + `dc_offset`).
  - `dc_en` has no effect in TONE and FSK.
- R9: Reset, idle and pulse behaviour.
  - Reset clears `sample_o`, `valid_o` and `conflict_o`.
  - IDLE produces no `valid_o`.
  - `valid_o` never lasts two cycles, and `sample_o` only changes with a `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | 1 | Tone enable |
| ring_en | input | 1 | Ring enable (highest priority) |
| fsk_en | input | 1 | Shift-keying enable, used with tone_en |
| fsk_bit | input | 1 | Serial data bit: 1 mark, 0 space |
| trap_sel | input | 1 | Ring waveform: 1 trapezoid, 0 sinusoid |
| dc_en | input | 1 | Ring DC offset enable |
| tone_coef | input | 16 | Tone coefficient, signed, 14 fraction bits |
| tone_amp | input | 16 | Tone start amplitude, signed |
| mark_coef | input | 16 | Mark coefficient |
| mark_amp | input | 16 | Mark start amplitude |
| space_coef | input | 16 | Space coefficient |
| space_amp | input | 16 | Space start amplitude |
| ring_coef | input | 16 | Ring coefficient |
| ring_amp | input | 16 | Ring start amplitude / trapezoid peak |
| trap_step | input | 16 | Trapezoid slope per sample, unsigned |
| trap_half | input | 16 | Samples per trapezoid half-cycle, at least 1 |
| dc_offset | input | 16 | Ring DC offset, signed |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | One-cycle pulse marking a new sample |
| conflict_o | output | 1 | Tone and ring both enabled |

## Verification
The bench drives inputs half a cycle before the clock edge that samples them. It time-stamps every `valid_o` pulse at the falling edge that follows it.

Timing expectations:
- The first sample of a burst is due DIV+1 cycles after the enables were driven: one cycle to register the mode, then DIV cycles of counting.
- Each later sample is due DIV cycles after the previous one.
- `conflict_o` is due one cycle after the enables.
- A change of `fsk_bit`, driven just after a sample, takes effect on the very next sample.

Sample values are compared in order against a resonator, trapezoid and offset model computed in the bench.

// File: rtl/reso_pkg.sv
package reso_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_FRAC = 14;
    localparam int ACC_W     = 2 * SAMPLE_W + 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TONE = 2'd1,
        ST_FSK  = 2'd2,
        ST_RING = 2'd3
    } st_t;

    function automatic sample_t sat_acc(input acc_t v);
        acc_t hi;
        acc_t lo;
        hi = '0;
        hi[SAMPLE_W-2:0] = '1;
        lo = '1;
        lo[SAMPLE_W-2:0] = '0;
        if (v > hi)
            return hi[SAMPLE_W-1:0];
        else if (v < lo)
            return lo[SAMPLE_W-1:0];
        else
            return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/reso_rate_gen.sv
module reso_rate_gen import reso_pkg::*; #(
    parameter int TONE_DIV = 6250,
    parameter int RING_DIV = 50000,
    parameter int FSK_DIV  = 2083
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  st_t  mode,
    output logic tick
);
    localparam int MAX_TF = (TONE_DIV > FSK_DIV) ? TONE_DIV : FSK_DIV;
    localparam int MAX_D  = (MAX_TF > RING_DIV) ? MAX_TF : RING_DIV;
    localparam int CW     = $clog2(MAX_D + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        unique case (mode)
            ST_TONE: last = CW'(TONE_DIV - 1);
            ST_FSK:  last = CW'(FSK_DIV - 1);
            ST_RING: last = CW'(RING_DIV - 1);
            default: last = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || cnt_q == last)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == last);

endmodule

// File: rtl/reso_osc.sv
module reso_osc import reso_pkg::*; (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step,
    input  logic    restart,
    input  sample_t coef,
    input  sample_t amp,
    output sample_t y_next
);
    sample_t y1_q;
    sample_t y2_q;
    sample_t src1;
    sample_t src2;
    acc_t    prod;
    acc_t    scaled;

    always_comb begin
        src1   = restart ? '0 : y1_q;
        src2   = restart ? amp : y2_q;
        prod   = acc_t'(coef) * acc_t'(src1);
        scaled = prod >>> (COEF_FRAC - 1);
        y_next = sat_acc(scaled - acc_t'(src2));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y1_q <= '0;
            y2_q <= '0;
        end else if (step) begin
            y1_q <= y_next;
            y2_q <= src1;
        end
    end

endmodule

// File: rtl/reso_trap.sv
module reso_trap import reso_pkg::*; (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                restart,
    input  sample_t             amp,
    input  logic [SAMPLE_W-1:0] slope,
    input  logic [SAMPLE_W-1:0] half,
    output sample_t             v_next
);
    sample_t             v_q;
    logic                rising_q;
    logic [SAMPLE_W-1:0] cnt_q;
    sample_t             src_v;
    logic                src_rise;
    logic [SAMPLE_W-1:0] src_cnt;
    acc_t                moved;
    acc_t                peak;

    always_comb begin
        src_v    = restart ? '0 : v_q;
        src_rise = restart ? 1'b1 : rising_q;
        src_cnt  = restart ? '0 : cnt_q;
        peak     = acc_t'(amp);
        if (src_rise) begin
            moved = acc_t'(src_v) + acc_t'({1'b0, slope});
            if (moved > peak)
                moved = peak;
        end else begin
            moved = acc_t'(src_v) - acc_t'({1'b0, slope});
            if (moved < -peak)
                moved = -peak;
        end
        v_next = sat_acc(moved);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q      <= '0;
            rising_q <= 1'b1;
            cnt_q    <= '0;
        end else if (step) begin
            v_q <= v_next;
            if (src_cnt == half - SAMPLE_W'(1)) begin
                cnt_q    <= '0;
                rising_q <= !src_rise;
            end else begin
                cnt_q    <= src_cnt + 1'b1;
                rising_q <= src_rise;
            end
        end
    end

endmodule

// File: rtl/reso_wavegen.sv
module reso_wavegen import reso_pkg::*; #(
    parameter int TONE_DIV = 6250,
    parameter int RING_DIV = 50000,
    parameter int FSK_DIV  = 2083
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tone_en,
    input  logic                       ring_en,
    input  logic                       fsk_en,
    input  logic                       fsk_bit,
    input  logic                       trap_sel,
    input  logic                       dc_en,
    input  logic signed [SAMPLE_W-1:0] tone_coef,
    input  logic signed [SAMPLE_W-1:0] tone_amp,
    input  logic signed [SAMPLE_W-1:0] mark_coef,
    input  logic signed [SAMPLE_W-1:0] mark_amp,
    input  logic signed [SAMPLE_W-1:0] space_coef,
    input  logic signed [SAMPLE_W-1:0] space_amp,
    input  logic signed [SAMPLE_W-1:0] ring_coef,
    input  logic signed [SAMPLE_W-1:0] ring_amp,
    input  logic        [SAMPLE_W-1:0] trap_step,
    input  logic        [SAMPLE_W-1:0] trap_half,
    input  logic signed [SAMPLE_W-1:0] dc_offset,
    output logic signed [SAMPLE_W-1:0] sample_o,
    output logic                       valid_o,
    output logic                       conflict_o
);
    st_t     state_q;
    st_t     state_d;
    logic    run;
    logic    tick;
    logic    fresh_q;
    logic    bit_used_q;
    logic    restart;
    sample_t sel_coef;
    sample_t sel_amp;
    sample_t osc_y;
    sample_t trap_y;
    sample_t wave;
    sample_t out_val;
    acc_t    off;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state: ring beats shift-keying beats plain tone
    always_comb begin
        if (ring_en)
            state_d = ST_RING;
        else if (tone_en && fsk_en)
            state_d = ST_FSK;
        else if (tone_en)
            state_d = ST_TONE;
        else
            state_d = ST_IDLE;
    end

    assign run = (state_q != ST_IDLE) && (state_d == state_q);

    reso_rate_gen #(
        .TONE_DIV (TONE_DIV),
        .RING_DIV (RING_DIV),
        .FSK_DIV  (FSK_DIV)
    ) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .mode  (state_q),
        .tick  (tick)
    );

    // Burst-start and mark/space bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q    <= 1'b1;
            bit_used_q <= 1'b0;
        end else begin
            if (!run)
                fresh_q <= 1'b1;
            else if (tick)
                fresh_q <= 1'b0;
            if (tick)
                bit_used_q <= fsk_bit;
        end
    end

    assign restart = fresh_q || ((state_q == ST_FSK) && (fsk_bit != bit_used_q));

    // Per-state oscillator settings
    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                sel_coef = '0;
                sel_amp  = '0;
            end
            ST_TONE: begin
                sel_coef = tone_coef;
                sel_amp  = tone_amp;
            end
            ST_FSK: begin
                sel_coef = fsk_bit ? mark_coef : space_coef;
                sel_amp  = fsk_bit ? mark_amp  : space_amp;
            end
            ST_RING: begin
                sel_coef = ring_coef;
                sel_amp  = ring_amp;
            end
        endcase
    end

    reso_osc u_osc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tick),
        .restart (restart),
        .coef    (sel_coef),
        .amp     (sel_amp),
        .y_next  (osc_y)
    );

    reso_trap u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (tick),
        .restart (restart),
        .amp     (ring_amp),
        .slope   (trap_step),
        .half    (trap_half),
        .v_next  (trap_y)
    );

    // Waveform choice and ringing offset
    always_comb begin
        unique case (state_q)
            ST_RING: begin
                wave = trap_sel ? trap_y : osc_y;
                off  = dc_en ? acc_t'(dc_offset) : '0;
            end
            default: begin
                wave = osc_y;
                off  = '0;
            end
        endcase
        out_val = sat_acc(acc_t'(wave) + off);
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_o   <= '0;
            valid_o    <= 1'b0;
            conflict_o <= 1'b0;
        end else begin
            valid_o    <= tick;
            conflict_o <= tone_en && ring_en;
            if (tick)
                sample_o <= out_val;
        end
    end

endmodule

// File: rtl/reso_wavegen_chk.sv
module reso_wavegen_chk import reso_pkg::*; (
    input logic    clk,
    input logic    rst_n,
    input logic    tone_en,
    input logic    ring_en,
    input logic    valid_o,
    input logic    conflict_o,
    input sample_t sample_o,
    input st_t     state_q
);
    assert_conflict_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_en && ring_en) |=> conflict_o);

    assert_conflict_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_en && ring_en) |=> !conflict_o);

    assert_ring_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ring_en |=> (state_q == ST_RING));

    assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !valid_o);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_hold_sample_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(sample_o));

endmodule

bind reso_wavegen reso_wavegen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_en    (tone_en),
    .ring_en    (ring_en),
    .valid_o    (valid_o),
    .conflict_o (conflict_o),
    .sample_o   (sample_o),
    .state_q    (state_q)
);

// File: tb/reso_wavegen_tb.sv
module reso_wavegen_tb;
    localparam int TD = 6;
    localparam int RD = 48;
    localparam int FD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_en = 0, ring_en = 0, fsk_en = 0, fsk_bit = 0, trap_sel = 0, dc_en = 0;
    logic signed [15:0] tone_coef = 0, tone_amp = 0, mark_coef = 0, mark_amp = 0;
    logic signed [15:0] space_coef = 0, space_amp = 0, ring_coef = 0, ring_amp = 0;
    logic [15:0] trap_step = 0, trap_half = 1;
    logic signed [15:0] dc_offset = 0;
    logic signed [15:0] sample_o;
    logic valid_o, conflict_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int t0 = 0;
    int nrec = 0;
    logic signed [15:0] rec_s [64];
    int rec_c [64];

    reso_wavegen #(.TONE_DIV(TD), .RING_DIV(RD), .FSK_DIV(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .ring_en(ring_en),
        .fsk_en(fsk_en), .fsk_bit(fsk_bit), .trap_sel(trap_sel), .dc_en(dc_en),
        .tone_coef(tone_coef), .tone_amp(tone_amp), .mark_coef(mark_coef),
        .mark_amp(mark_amp), .space_coef(space_coef), .space_amp(space_amp),
        .ring_coef(ring_coef), .ring_amp(ring_amp), .trap_step(trap_step),
        .trap_half(trap_half), .dc_offset(dc_offset), .sample_o(sample_o),
        .valid_o(valid_o), .conflict_o(conflict_o));

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && valid_o && nrec < 64) begin
            rec_s[nrec] = sample_o;
            rec_c[nrec] = cyc;
            nrec = nrec + 1;
        end
    end

    task automatic chk(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic longint satv(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic set_mode(input logic t, input logic r, input logic f);
        @(negedge clk);
        #1;
        nrec = 0;
        t0 = cyc;
        tone_en = t;
        ring_en = r;
        fsk_en = f;
    endtask

    task automatic wait_n(input int n);
        while (nrec < n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic go_idle();
        set_mode(0, 0, 0);
        repeat (5) @(negedge clk);
    endtask

    // Sinusoid reference from a fresh start: y1 = 0, y2 = amplitude
    task automatic check_osc(input string rq, input longint c, input longint a,
                             input longint off, input int start, input int n);
        longint y1, y2, e;
        y1 = 0;
        y2 = a;
        for (int k = 0; k < n; k++) begin
            e = satv(((c * y1) >>> 13) - y2);
            y2 = y1;
            y1 = e;
            chk(rq, rec_s[start + k], satv(e + off));
        end
    endtask

    task automatic check_trap(input string rq, input longint a, input longint st,
                              input int h, input longint off, input int n);
        longint v;
        bit up;
        int cnt;
        v = 0;
        up = 1;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            if (up) v = (v + st > a) ? a : v + st;
            else    v = (v - st < -a) ? -a : v - st;
            chk(rq, rec_s[k], satv(v + off));
            if (cnt == h - 1) begin
                cnt = 0;
                up = !up;
            end else begin
                cnt++;
            end
        end
    endtask

    task automatic check_timing(input string rq, input int div, input int n);
        chk(rq, rec_c[0] - t0, div + 1);
        for (int k = 1; k < n; k++)
            chk(rq, rec_c[k] - rec_c[k-1], div);
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset sample", sample_o, 0);
        chk("R9 reset valid", valid_o, 0);
        chk("R9 reset conflict", conflict_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1/R2: tone bursts, several coefficient/amplitude patterns
        tone_coef = 16'sd15137; tone_amp = 16'sd2000;
        set_mode(1, 0, 0);
        wait_n(12);
        check_osc("R1 tone A", 15137, 2000, 0, 0, 12);
        check_timing("R2 tone rate", TD, 12);

        // R5: same burst again after idle restarts from the same phase
        go_idle();
        set_mode(1, 0, 0);
        wait_n(8);
        check_osc("R5 tone restart", 15137, 2000, 0, 0, 8);

        // R8: dc offset ignored in tone mode
        go_idle();
        tone_coef = 16'sd8192; tone_amp = -16'sd5000;
        dc_en = 1; dc_offset = 16'sd3000;
        set_mode(1, 0, 0);
        wait_n(10);
        check_osc("R8 tone no offset", 8192, -5000, 0, 0, 10);
        dc_en = 0;

        // R1: saturation with growing coefficient
        go_idle();
        tone_coef = 16'sd32000; tone_amp = 16'sd20000;
        set_mode(1, 0, 0);
        wait_n(12);
        check_osc("R1 saturate", 32000, 20000, 0, 0, 12);

        // R9: idle issues nothing
        go_idle();
        nrec = 0;
        repeat (200) @(negedge clk);
        chk("R9 idle silent", nrec, 0);

        // R2/R8: ring sinusoid with dc offset
        ring_coef = 16'sd16300; ring_amp = 16'sd3000;
        dc_en = 1; dc_offset = 16'sd1000; trap_sel = 0;
        set_mode(0, 1, 0);
        wait_n(10);
        check_osc("R8 ring offset", 16300, 3000, 1000, 0, 10);
        check_timing("R2 ring rate", RD, 10);
        dc_en = 0;

        // R5: direct ring -> tone change restarts, no idle in between
        tone_coef = 16'sd12000; tone_amp = 16'sd700;
        set_mode(1, 0, 0);
        wait_n(8);
        check_osc("R5 direct change", 12000, 700, 0, 0, 8);
        check_timing("R5 change timing", TD, 8);

        // R7: trapezoid, A=1000 step=300 half=6
        go_idle();
        ring_amp = 16'sd1000; trap_step = 16'd300; trap_half = 16'd6; trap_sel = 1;
        set_mode(0, 1, 0);
        wait_n(20);
        check_trap("R7 trapezoid", 1000, 300, 6, 0, 20);

        // R8: trapezoid plus large offset saturates
        go_idle();
        dc_en = 1; dc_offset = 16'sd32000;
        set_mode(0, 1, 0);
        wait_n(14);
        check_trap("R8 offset saturate", 1000, 300, 6, 32000, 14);
        dc_en = 0; trap_sel = 0;

        // R6/R3: shift keying beats plain tone; mark -> space -> mark
        go_idle();
        mark_coef = 16'sd12000; mark_amp = 16'sd1500;
        space_coef = 16'sd5000; space_amp = 16'sd2500;
        fsk_bit = 1;
        set_mode(1, 0, 1);
        wait_n(5);
        fsk_bit = 0;
        wait_n(10);
        fsk_bit = 1;
        wait_n(14);
        check_osc("R6 mark", 12000, 1500, 0, 0, 5);
        check_osc("R6 space", 5000, 2500, 0, 5, 5);
        check_osc("R6 mark again", 12000, 1500, 0, 10, 4);
        check_timing("R2 fsk rate", FD, 14);

        // R4/R3: tone and ring both on, ring output wins
        go_idle();
        ring_coef = 16'sd14000; ring_amp = 16'sd900;
        set_mode(1, 1, 1);
        @(posedge clk);
        @(negedge clk);
        chk("R4 conflict set", conflict_o, 1);
        wait_n(6);
        check_osc("R3 ring wins", 14000, 900, 0, 0, 6);
        set_mode(0, 1, 0);
        @(posedge clk);
        @(negedge clk);
        chk("R4 conflict clear", conflict_o, 0);

        go_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2ms;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule